// File: doc/BRIEF.md
# Multichannel Multilevel Wavelet Job Sequencer

This block schedules one shared lifting wavelet core across many recording channels and several dyadic decomposition levels. Samples arrive one at a time, each with a channel index, and one strobe per computation cycle. For each accepted sample the sequencer picks a job: a level-1 step when the sample completes a pair, or, when it is the first of a pair, a pending higher-level step for the same channel. The first sample of a pair is parked in an input buffer during this holding cycle. The sequencer then drives the addresses, read and write enables, operand load strobes and core slot strobes that the surrounding datapath and memories need.

A computation cycle lasts a fixed number of clock slots. The first slot loads all operand registers in parallel from the per-channel/level state word and from the input path (the stream plus the input buffer, or the two parked values in the pairing memory). The core then runs through its slots, and the last slot writes the state word back and sends out the results. Approximation results below the top level are parked in the pairing memory. At the top level they go to the output bus. The detail result always goes to the output bus, tagged with an 8-bit job marker. The master clock is expected to run at the slot count times the sample rate times the channel count.

Top module: `dwt_seq`

## Requirements
- R1: After reset, and while no sample has been accepted, every enable, strobe and valid output is 0.
- R2: A sample strobe accepted when the sequencer is idle or in its final slot starts a cycle of SLOTS (8) slots: slot 1 loads, slots 2..CORE_SLOTS+1 drive core_slot_o one-hot from bit 0 upward, and slot 8 writes back. A strobe during slots 1..7 is ignored and changes no channel's schedule.
- R3: Per channel, counting from reset, the 2nd, 4th, ... accepted sample runs a level-1 job (level field 0) with src_sel_o = 0 (input stream and input buffer).
- R4: The 1st, 3rd, ... sample of a channel asserts in_buf_we_o in the load slot and runs the lowest pending higher level of that channel with src_sel_o = 1 and pair_rd_addr_o = ch*(NUM_LVL-1) + level_field - 1. If none is pending, no operand load, state read/write, core slot or output valid occurs.
- R5: In the load slot of a job, all six bits of opnd_ld_o are 1 together with cl_rd_o, and cl_addr_o = ch*NUM_LVL + level_field.
- R6: In the write-back slot of a job, cl_we_o and det_vld_o are 1 and marker_o holds the job's tag unchanged since the load slot.
- R7: A job below the top level writes its approximation to the pairing memory (pair_we_o = 1, pair_wr_addr_o = ch*(NUM_LVL-1) + level_field, pair_wr_sel_o = 0 then 1 alternating per channel and level from reset), with approx_vld_o = 0. A top-level job (level field NUM_LVL-1) asserts approx_vld_o and not pair_we_o.
- R8: A level becomes pending for a channel after every second completion of the level below. A pairing entry is read only after both of its halves were written since its last read.
- R9: marker_o = {channel[4:0], level_field[2:0]}, level field 0 meaning level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One strobe per incoming sample |
| sample_ch_i | input | 5 | Channel of the incoming sample |
| marker_o | output | 8 | Job tag {channel, level field} |
| cl_addr_o | output | 7 | Channel/level state word address |
| cl_rd_o | output | 1 | State word read (load slot) |
| cl_we_o | output | 1 | State word write (write-back slot) |
| opnd_ld_o | output | 6 | Operand register load strobes |
| core_slot_o | output | 6 | One-hot core slot strobe |
| src_sel_o | output | 1 | Input source: 0 stream/buffer, 1 pairing memory |
| in_buf_we_o | output | 1 | Park the first sample of a pair |
| pair_rd_o | output | 1 | Pairing memory read |
| pair_rd_addr_o | output | 7 | Pairing memory read address |
| pair_we_o | output | 1 | Pairing memory write of the approximation |
| pair_wr_addr_o | output | 7 | Pairing memory write address |
| pair_wr_sel_o | output | 1 | Half of the pairing entry written |
| det_vld_o | output | 1 | Detail result valid on the output bus |
| approx_vld_o | output | 1 | Top-level approximation valid on the output bus |

## Verification
On every cycle the assertions check the slot ordering and the one-hot core strobe, that write-back follows the last core slot, that the pairing write and the top-level approximation valid are never both asserted, that a holding cycle never starts a level-1 job, and that a level is never marked pending while it is still pending. Only the bench's scenarios can show the job schedule itself: which level each sample triggers across all 32 channels over 24 rounds, when level 4 first appears, the exact addresses and pairing halves, that pairing reads follow two writes, and that a stray strobe in mid-cycle leaves every later job unchanged.

// File: rtl/dwt_seq_pkg.sv
package dwt_seq_pkg;
  localparam int MARK_LVL_W = 3;
  localparam int NUM_IV     = 4;  // intermediate operands per job
  localparam int NUM_IN     = 2;  // input operands per job
  localparam int NUM_OPND   = NUM_IV + NUM_IN;
  typedef logic [MARK_LVL_W-1:0] lvl_t;
endpackage

// File: rtl/dwt_seq_timer.sv
module dwt_seq_timer #(
  parameter int SLOTS      = 8,
  parameter int CORE_SLOTS = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  output logic                  start_o,
  output logic                  busy_o,
  output logic                  load_o,
  output logic                  wb_o,
  output logic [CORE_SLOTS-1:0] slot_o
);
  logic [3:0] st_q;

  assign start_o = valid_i && (st_q == 4'd0 || st_q == 4'(SLOTS));
  assign busy_o  = st_q != 4'd0;
  assign load_o  = st_q == 4'd1;
  assign wb_o    = st_q == 4'(SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 st_q <= 4'd0;
    else if (start_o)            st_q <= 4'd1;
    else if (st_q == 4'(SLOTS))  st_q <= 4'd0;
    else if (st_q != 4'd0)       st_q <= st_q + 4'd1;
  end

  for (genvar k = 0; k < CORE_SLOTS; k++) begin : g_slot
    assign slot_o[k] = st_q == 4'(k + 2);
  end

  // R2
  slot_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_o));
  // R2
  load_to_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> slot_o[0]);
  // R2
  last_to_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o[CORE_SLOTS-1] && (CORE_SLOTS + 2 == SLOTS) |=> wb_o);
endmodule

// File: rtl/dwt_seq_sched.sv
module dwt_seq_sched
  import dwt_seq_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_LVL = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int LI_W   = $clog2(NUM_LVL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            wb_i,
  output logic            job_vld_o,
  output logic            hold_o,
  output logic [CH_W-1:0] ch_o,
  output lvl_t            lvl_o,
  output logic            top_o,
  output logic            wr_sel_o
);
  logic [NUM_CH-1:0]  samp_par_q;
  logic [NUM_LVL-1:1] pend_q [NUM_CH];
  logic [NUM_LVL-2:0] apar_q [NUM_CH];
  logic               job_vld_q, hold_q;
  logic [CH_W-1:0]    ch_q;
  lvl_t               lvl_q;
  logic               sel_vld;
  lvl_t               sel_lvl;
  logic [LI_W-1:0]    lvl_li, nxt_li;
  logic               adv, cur_par, set_pend;

  // pair-completing sample runs level 1, else lowest pending level wins
  always_comb begin
    sel_vld = 1'b0;
    sel_lvl = '0;
    if (samp_par_q[ch_i]) begin
      sel_vld = 1'b1;
    end else begin
      for (int j = NUM_LVL - 1; j >= 1; j--) begin
        if (pend_q[ch_i][j]) begin
          sel_vld = 1'b1;
          sel_lvl = MARK_LVL_W'(j);
        end
      end
    end
  end

  assign lvl_li   = lvl_q[LI_W-1:0];
  assign nxt_li   = lvl_li + LI_W'(1);
  assign top_o    = lvl_q == MARK_LVL_W'(NUM_LVL - 1);
  assign adv      = wb_i && job_vld_q && !top_o;
  assign cur_par  = top_o ? 1'b0 : apar_q[ch_q][lvl_li];
  assign set_pend = adv && cur_par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_par_q <= '0;
      job_vld_q  <= 1'b0;
      hold_q     <= 1'b0;
      ch_q       <= '0;
      lvl_q      <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        pend_q[c] <= '0;
        apar_q[c] <= '0;
      end
    end else begin
      if (start_i) begin
        samp_par_q[ch_i] <= ~samp_par_q[ch_i];
        ch_q      <= ch_i;
        job_vld_q <= sel_vld;
        hold_q    <= ~samp_par_q[ch_i];
        lvl_q     <= sel_lvl;
        if (!samp_par_q[ch_i] && sel_vld) pend_q[ch_i][sel_lvl[LI_W-1:0]] <= 1'b0;
      end
      if (adv) begin
        apar_q[ch_q][lvl_li] <= ~cur_par;
        if (cur_par) pend_q[ch_q][nxt_li] <= 1'b1;
      end
    end
  end

  assign job_vld_o = job_vld_q;
  assign hold_o    = hold_q;
  assign ch_o      = ch_q;
  assign lvl_o     = lvl_q;
  assign wr_sel_o  = cur_par;

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pend |-> !pend_q[ch_q][nxt_li]);
endmodule

// File: rtl/dwt_seq_addr.sv
module dwt_seq_addr #(
  parameter int NUM_CH  = 32,
  parameter int NUM_LVL = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int LI_W   = $clog2(NUM_LVL),
  localparam int CL_AW  = $clog2(NUM_CH * NUM_LVL),
  localparam int PR_AW  = $clog2(NUM_CH * (NUM_LVL - 1))
) (
  input  logic [CH_W-1:0]  ch_i,
  input  logic [LI_W-1:0]  lvl_i,
  output logic [CL_AW-1:0] cl_addr_o,
  output logic [PR_AW-1:0] pr_rd_addr_o,
  output logic [PR_AW-1:0] pr_wr_addr_o
);
  int unsigned base;
  assign base         = int'(ch_i) * (NUM_LVL - 1);
  assign cl_addr_o    = CL_AW'(int'(ch_i) * NUM_LVL + int'(lvl_i));
  // reader of level k fetches what level k-1 parked
  assign pr_rd_addr_o = PR_AW'(base + int'(lvl_i) - 1);
  assign pr_wr_addr_o = PR_AW'(base + int'(lvl_i));
endmodule

// File: rtl/dwt_seq.sv
module dwt_seq
  import dwt_seq_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int NUM_LVL    = 4,
  parameter int SLOTS      = 8,
  parameter int CORE_SLOTS = 6,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int LI_W      = $clog2(NUM_LVL),
  localparam int CL_AW     = $clog2(NUM_CH * NUM_LVL),
  localparam int PR_AW     = $clog2(NUM_CH * (NUM_LVL - 1))
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic [CH_W-1:0]            sample_ch_i,
  output logic [CH_W+MARK_LVL_W-1:0] marker_o,
  output logic [CL_AW-1:0]           cl_addr_o,
  output logic                       cl_rd_o,
  output logic                       cl_we_o,
  output logic [NUM_OPND-1:0]        opnd_ld_o,
  output logic [CORE_SLOTS-1:0]      core_slot_o,
  output logic                       src_sel_o,
  output logic                       in_buf_we_o,
  output logic                       pair_rd_o,
  output logic [PR_AW-1:0]           pair_rd_addr_o,
  output logic                       pair_we_o,
  output logic [PR_AW-1:0]           pair_wr_addr_o,
  output logic                       pair_wr_sel_o,
  output logic                       det_vld_o,
  output logic                       approx_vld_o
);
  logic                  start, busy, load, wb;
  logic [CORE_SLOTS-1:0] slot;
  logic                  job, hold, top, wr_sel, upper;
  logic [CH_W-1:0]       ch;
  lvl_t                  lvl;
  logic [CL_AW-1:0]      cl_addr;
  logic [PR_AW-1:0]      pr_rd, pr_wr;

  dwt_seq_timer #(.SLOTS(SLOTS), .CORE_SLOTS(CORE_SLOTS)) u_timer (
    .clk_i, .rst_ni, .valid_i(sample_valid_i), .start_o(start),
    .busy_o(busy), .load_o(load), .wb_o(wb), .slot_o(slot));

  dwt_seq_sched #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL)) u_sched (
    .clk_i, .rst_ni, .start_i(start), .ch_i(sample_ch_i), .wb_i(wb),
    .job_vld_o(job), .hold_o(hold), .ch_o(ch), .lvl_o(lvl), .top_o(top),
    .wr_sel_o(wr_sel));

  dwt_seq_addr #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL)) u_addr (
    .ch_i(ch), .lvl_i(lvl[LI_W-1:0]), .cl_addr_o(cl_addr),
    .pr_rd_addr_o(pr_rd), .pr_wr_addr_o(pr_wr));

  assign upper          = lvl != '0;
  assign marker_o       = {ch, lvl};
  assign cl_addr_o      = cl_addr;
  assign cl_rd_o        = load && job;
  assign cl_we_o        = wb && job;
  assign opnd_ld_o      = {NUM_OPND{load && job}};
  assign core_slot_o    = job ? slot : '0;
  assign src_sel_o      = busy && job && upper;
  assign in_buf_we_o    = load && hold;
  assign pair_rd_o      = load && job && upper;
  assign pair_rd_addr_o = pair_rd_o ? pr_rd : '0;
  assign pair_we_o      = wb && job && !top;
  assign pair_wr_addr_o = pair_we_o ? pr_wr : '0;
  assign pair_wr_sel_o  = pair_we_o && wr_sel;
  assign det_vld_o      = wb && job;
  assign approx_vld_o   = wb && job && top;

  // R7
  approx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pair_we_o && approx_vld_o));
  // R4
  hold_no_l1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_buf_we_o |-> !(cl_rd_o && !src_sel_o));
  // R6
  wb_after_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_slot_o[CORE_SLOTS-1] && (CORE_SLOTS + 2 == SLOTS) |=> cl_we_o && det_vld_o);
  // R6
  tag_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_vld_o |-> $stable(marker_o));
endmodule

// File: tb/dwt_seq_tb.sv
module dwt_seq_tb;
  localparam int NCH = 32;
  localparam int NLV = 4;
  localparam int ROUNDS = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [4:0] sch = '0;
  logic [7:0] marker;
  logic [6:0] cl_addr, prd_addr, pwr_addr;
  logic       cl_rd, cl_we, src_sel, in_we, prd, pwe, pwsel, det, apx;
  logic [5:0] opnd, cslot;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  int samp_n [NCH];
  bit apar_m [NCH][NLV];
  bit pend_m [NCH][NLV];
  bit pmask  [NCH*(NLV-1)][2];

  always #4 clk = ~clk;

  dwt_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(vld), .sample_ch_i(sch),
    .marker_o(marker), .cl_addr_o(cl_addr), .cl_rd_o(cl_rd), .cl_we_o(cl_we),
    .opnd_ld_o(opnd), .core_slot_o(cslot), .src_sel_o(src_sel),
    .in_buf_we_o(in_we), .pair_rd_o(prd), .pair_rd_addr_o(prd_addr),
    .pair_we_o(pwe), .pair_wr_addr_o(pwr_addr), .pair_wr_sel_o(pwsel),
    .det_vld_o(det), .approx_vld_o(apx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({cl_rd, cl_we, in_we, prd, pwe, det, apx, src_sel} == 0 && opnd == 0 && cslot == 0,
        req, int'({cl_rd, cl_we, in_we, prd, pwe, det, apx}), 0);
  endtask

  task automatic do_sample(input int ch, input bit intrude);
    bit hold, jv;
    int jl, exp_tag, pa;
    hold = (samp_n[ch] % 2) == 0;
    jv = 1'b0; jl = 0;
    if (!hold) begin
      jv = 1'b1;
    end else begin
      for (int j = NLV - 1; j >= 1; j--)
        if (pend_m[ch][j]) begin jv = 1'b1; jl = j; end
      if (jv) pend_m[ch][jl] = 1'b0;
    end
    samp_n[ch]++;
    exp_tag = ch * 8 + jl;

    vld = 1'b1; sch = 5'(ch);
    @(negedge clk);
    vld = 1'b0;
    // load slot
    chk(cl_rd == jv, "R5 cl_rd", int'(cl_rd), int'(jv));
    chk(opnd == (jv ? 6'h3f : 6'h00), "R5 opnd_ld", int'(opnd), jv ? 63 : 0);
    chk(in_we == hold, "R4 in_buf_we", int'(in_we), int'(hold));
    if (jv) begin
      chk(int'(marker) == exp_tag, "R9 marker", int'(marker), exp_tag);
      chk(int'(cl_addr) == ch * NLV + jl, "R5 cl_addr", int'(cl_addr), ch * NLV + jl);
      if (jl == 0) chk(src_sel == 1'b0, "R3 src_sel", int'(src_sel), 0);
      else         chk(src_sel == 1'b1, "R4 src_sel", int'(src_sel), 1);
      chk(prd == (jl != 0), "R4 pair_rd", int'(prd), int'(jl != 0));
      if (jl != 0) begin
        pa = ch * (NLV - 1) + jl - 1;
        chk(int'(prd_addr) == pa, "R4 pair_rd_addr", int'(prd_addr), pa);
        chk(pmask[pa][0] && pmask[pa][1], "R8 pair read before both halves",
            int'({pmask[pa][1], pmask[pa][0]}), 3);
        pmask[pa][0] = 1'b0; pmask[pa][1] = 1'b0;
      end
    end else begin
      chk(prd == 1'b0, "R4 no job pair_rd", int'(prd), 0);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (intrude && k == 1) begin vld = 1'b1; sch = 5'((ch + 1) % NCH); end
      if (intrude && k == 2) vld = 1'b0;
      chk(cslot == (jv ? 6'(1 << k) : 6'h00), "R2 core_slot", int'(cslot), jv ? (1 << k) : 0);
    end
    @(negedge clk);
    // write-back slot
    chk(det == jv, "R6 det_vld", int'(det), int'(jv));
    chk(cl_we == jv, "R6 cl_we", int'(cl_we), int'(jv));
    if (jv) begin
      chk(int'(marker) == exp_tag, "R6 tag at write-back", int'(marker), exp_tag);
      chk(apx == (jl == NLV - 1), "R7 approx_vld", int'(apx), int'(jl == NLV - 1));
      chk(pwe == (jl < NLV - 1), "R7 pair_we", int'(pwe), int'(jl < NLV - 1));
      if (jl < NLV - 1) begin
        pa = ch * (NLV - 1) + jl;
        chk(int'(pwr_addr) == pa, "R7 pair_wr_addr", int'(pwr_addr), pa);
        chk(pwsel == apar_m[ch][jl], "R7 pair_wr_sel", int'(pwsel), int'(apar_m[ch][jl]));
        pmask[pa][apar_m[ch][jl]] = 1'b1;
        if (apar_m[ch][jl]) pend_m[ch][jl+1] = 1'b1;
        apar_m[ch][jl] = ~apar_m[ch][jl];
      end
    end else begin
      chk(pwe == 1'b0 && apx == 1'b0, "R4 no job outputs", int'({pwe, apx}), 0);
    end
  endtask

  initial begin
    int top_seen;
    top_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_idle("R1 reset idle");
    end
    for (int r = 0; r < ROUNDS; r++)
      for (int c = 0; c < NCH; c++) begin
        do_sample(c, r == 5 && c == 7);
        if (apx) top_seen++;
      end
    chk(top_seen > 0, "R8 top level reached", top_seen, 1);
    repeat (2) @(negedge clk);
    chk_idle("R1 idle after last job");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule